// File: doc/BRIEF.md
# Eight-Direction Toroidal Mesh Shifter

This block holds one data word for each processing element of a rows-by-columns grid. On one strobe, every element hands its word to the adjacent element in one of eight compass directions. All elements move together under the same direction code. Opposite edges of the grid are joined, so a word that leaves one side comes back in on the other side.

A per-element enable mask decides which elements accept the incoming word. A masked-off element keeps its own word, but its neighbours can still take that word from it. A zero-distance mode leaves every register as it is while the strobe still runs its normal cycle. A host port addresses one element by row and column. It can write that element's register or read it back.

The full-size configuration is a 64x64 grid of 32-bit words. The defaults are a 4x4 grid, which keeps elaboration and simulation small.

Top module: `mesh_shift_grid`

## Requirements
- R1: The direction code on `shift_dir` selects where each word moves. The codes are 0 north, 1 northeast, 2 east, 3 southeast, 4 south, 5 southwest, 6 west and 7 northwest. North lowers the row index and east raises the column index. An enabled element at (r,c) receives the word that was held by (r-dr, c-dc), where (dr,dc) is the direction's step.
- R2: Index arithmetic wraps modulo the grid size. A word moving north from row 0 lands in the last row. A word moving east from the last column lands in column 0. Diagonal moves wrap in both axes.
- R3: When `shift_zero` is high together with the strobe, no register changes.
- R4: An element whose bit in `en_mask` is low keeps its value during a shift. That element's old value is still delivered to its enabled neighbour. The mask bit of element (r,c) is r*COLS+c.
- R5: All enabled elements update on the same clock edge, the edge at which `shift_go` is sampled high. Every element uses the values held before that edge.
- R6: `shift_done` is high for exactly the one cycle after each edge at which `shift_go` was sampled high. It is low otherwise.
- R7: With `shift_go` low, `host_wr` writes `host_wdata` into element (`host_row`,`host_col`) at the clock edge. `host_rdata` always shows that element's register, combinationally.
- R8: A host write in a cycle where `shift_go` is high is ignored.
- R9: While `rst_n` is low, all registers clear to zero and `shift_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_go | input | 1 | Shift strobe |
| shift_zero | input | 1 | Zero-distance move: registers hold |
| shift_dir | input | 3 | Direction code |
| en_mask | input | ROWS*COLS | Per-element enable, bit r*COLS+c |
| host_wr | input | 1 | Host write strobe |
| host_row | input | RW | Host row address |
| host_col | input | CW | Host column address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Register of the addressed element |
| shift_done | output | 1 | One-cycle pulse after a shift |

## Verification
The bench runs each of the eight directions on a pattern where every element's value is unique. A design that mixed up source and destination, or swapped diagonals, would show words from the wrong neighbour.

Elements on the edges show whether wraparound is right. A design without wraparound would load a stale value or zero at the edges.

Sparse enable masks catch two faults. A design that let masked elements update would change those elements. A design that gated a masked element's output would starve its neighbours.

The remaining cases each target one failure:
- A zero-distance strobe shows whether registers hold; a design that moved data anyway would change them.
- A host write during a shift shows whether it is dropped; a design that accepted it would change the addressed element.
- Back-to-back strobes show whether `shift_done` tracks each one; a design that latched or stretched the pulse would hold it high too long.

// File: rtl/mesh_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the mesh shifter: direction codes and the
// constant functions that map a receiving element to its source element.
// Assumes row index grows southward and column index grows eastward.
package mesh_pkg;

    typedef enum logic [2:0] {
        DIR_N  = 3'd0,
        DIR_NE = 3'd1,
        DIR_E  = 3'd2,
        DIR_SE = 3'd3,
        DIR_S  = 3'd4,
        DIR_SW = 3'd5,
        DIR_W  = 3'd6,
        DIR_NW = 3'd7
    } mesh_dir_e;

    // Row step a word takes for direction code d
    function automatic int step_row(input int d);
        case (d)
            0, 1, 7: return -1;
            3, 4, 5: return 1;
            default: return 0;
        endcase
    endfunction

    // Column step a word takes for direction code d
    function automatic int step_col(input int d);
        case (d)
            1, 2, 3: return 1;
            5, 6, 7: return -1;
            default: return 0;
        endcase
    endfunction

    // Row of the element whose word lands on row r, with wraparound
    function automatic int src_row(input int r, input int d, input int rows);
        return (r - step_row(d) + rows) % rows;
    endfunction

    // Column of the element whose word lands on column c, with wraparound
    function automatic int src_col(input int c, input int d, input int cols);
        return (c - step_col(d) + cols) % cols;
    endfunction

endpackage

// File: rtl/mesh_dir_select.sv
`timescale 1ns/1ps
// Picks one of the eight neighbour words for a single element.
// Assumes the candidates are ordered by direction code.
module mesh_dir_select #(
    parameter int DW = 32
) (
    input  logic [7:0][DW-1:0] cand,
    input  logic [2:0]         dir,
    output logic [DW-1:0]      pick
);

    // Direction-indexed selection
    always_comb begin
        pick = cand[dir];
    end

endmodule

// File: rtl/mesh_pe_cell.sv
`timescale 1ns/1ps
// One element's data register. A shift load takes priority over a host load.
// Assumes the parent already gates shift_en with the strobe, the
// zero-distance flag and the mask bit, and gates load_en so that it is
// never set during a shift.
module mesh_pe_cell #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [DW-1:0] nbr_d,
    input  logic          load_en,
    input  logic [DW-1:0] load_d,
    output logic [DW-1:0] q
);

    // Register update: reset, neighbour word, host word, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= nbr_d;
        end else if (load_en) begin
            q <= load_d;
        end
    end

endmodule

// File: rtl/mesh_shift_grid.sv
`timescale 1ns/1ps
// Toroidal grid of element registers with a one-step, eight-direction
// neighbour shift, a per-element enable mask and a row/column host port.
// Assumes ROWS >= 2 and COLS >= 2. Mask bit of element (r,c) is r*COLS+c.
module mesh_shift_grid #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 32,
    localparam int NPE = ROWS * COLS,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_go,
    input  logic           shift_zero,
    input  logic [2:0]     shift_dir,
    input  logic [NPE-1:0] en_mask,
    input  logic           host_wr,
    input  logic [RW-1:0]  host_row,
    input  logic [CW-1:0]  host_col,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           shift_done
);
    import mesh_pkg::*;

    logic [NPE-1:0][DW-1:0] cell_q;
    logic                   move_ok;
    logic                   host_ok;

    // Shared gating terms: a real move, or a host write outside a shift
    always_comb begin
        move_ok = shift_go && !shift_zero;
        host_ok = host_wr && !shift_go;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [7:0][DW-1:0] cand;
            logic [DW-1:0]      nbr;
            logic               addr_hit;

            for (genvar d = 0; d < 8; d++) begin : g_dir
                localparam int SR = src_row(r, d, ROWS);
                localparam int SC = src_col(c, d, COLS);
                assign cand[d] = cell_q[SR * COLS + SC];
            end

            // Host address decode for this element
            always_comb begin
                addr_hit = (host_row == RW'(r)) && (host_col == CW'(c));
            end

            mesh_dir_select #(.DW(DW)) u_sel (
                .cand (cand),
                .dir  (shift_dir),
                .pick (nbr)
            );

            mesh_pe_cell #(.DW(DW)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (move_ok && en_mask[IDX]),
                .nbr_d    (nbr),
                .load_en  (host_ok && addr_hit),
                .load_d   (host_wdata),
                .q        (cell_q[IDX])
            );
        end
    end

    // Host read: the addressed element's register, combinationally
    always_comb begin
        host_rdata = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if ((host_row == RW'(r)) && (host_col == CW'(c))) begin
                    host_rdata = cell_q[r * COLS + c];
                end
            end
        end
    end

    // Done pulse: one cycle after the strobe is sampled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_done <= 1'b0;
        end else begin
            shift_done <= shift_go;
        end
    end

endmodule

// File: rtl/mesh_shift_grid_chk.sv
`timescale 1ns/1ps
// Property checker for mesh_shift_grid, attached by bind.
// Watches the grid registers and the done pulse.
module mesh_shift_grid_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 32,
    localparam int NPE = ROWS * COLS,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   shift_go,
    input logic                   shift_zero,
    input logic [2:0]             shift_dir,
    input logic [NPE-1:0]         en_mask,
    input logic                   host_wr,
    input logic [RW-1:0]          host_row,
    input logic [CW-1:0]          host_col,
    input logic [DW-1:0]          host_wdata,
    input logic                   shift_done,
    input logic [NPE-1:0][DW-1:0] cell_q
);
    import mesh_pkg::*;

    AST_DONE_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> shift_done); // R6
    AST_DONE_ONLY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_go |=> !shift_done); // R6

    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            localparam int IDX = r * COLS + c;
            for (genvar d = 0; d < 8; d++) begin : g_d
                localparam int SIDX = src_row(r, d, ROWS) * COLS + src_col(c, d, COLS);
                AST_MOVE_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
                    (shift_go && !shift_zero && en_mask[IDX] && shift_dir == 3'(d))
                    |=> cell_q[IDX] == $past(cell_q[SIDX])); // R1
            end
            AST_HOLD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_go && (shift_zero || !en_mask[IDX])) |=> $stable(cell_q[IDX])); // R4
            AST_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (!shift_go && host_wr && host_row == RW'(r) && host_col == CW'(c))
                |=> cell_q[IDX] == $past(host_wdata)); // R7
            AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                (!shift_go && !(host_wr && host_row == RW'(r) && host_col == CW'(c)))
                |=> $stable(cell_q[IDX])); // R8
        end
    end

endmodule

bind mesh_shift_grid mesh_shift_grid_chk #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_go   (shift_go),
    .shift_zero (shift_zero),
    .shift_dir  (shift_dir),
    .en_mask    (en_mask),
    .host_wr    (host_wr),
    .host_row   (host_row),
    .host_col   (host_col),
    .host_wdata (host_wdata),
    .shift_done (shift_done),
    .cell_q     (cell_q)
);

// File: tb/sim_mesh_shift_grid.sv
`timescale 1ns/1ps
// Directed bench for mesh_shift_grid on a 4x4 grid, one task per scenario.
module sim_mesh_shift_grid;
    localparam int R = 4;
    localparam int C = 4;
    localparam int N = R * C;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          shift_go, shift_zero, host_wr;
    logic [2:0]    shift_dir;
    logic [N-1:0]  en_mask;
    logic [1:0]    host_row, host_col;
    logic [31:0]   host_wdata, host_rdata;
    logic          shift_done;

    logic [31:0] mdl [R][C];
    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    mesh_shift_grid #(.ROWS(R), .COLS(C), .DW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_go(shift_go), .shift_zero(shift_zero),
        .shift_dir(shift_dir), .en_mask(en_mask), .host_wr(host_wr),
        .host_row(host_row), .host_col(host_col), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .shift_done(shift_done)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Read every element through the host port and compare with the model
    task automatic check_grid(input string req);
        for (int r = 0; r < R; r++) begin
            for (int c = 0; c < C; c++) begin
                host_row = 2'(r);
                host_col = 2'(c);
                #1;
                check(req, host_rdata, mdl[r][c]);
            end
        end
    endtask

    task automatic host_write(input int r, input int c, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_row = 2'(r); host_col = 2'(c); host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        mdl[r][c] = v;
    endtask

    task automatic load_pattern(input logic [31:0] seed);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                host_write(r, c, seed ^ (32'(r * 16 + c) * 32'h0101_0101));
    endtask

    // Reference move computed from the direction steps in R1
    task automatic model_shift(input int d, input logic z, input logic [N-1:0] m);
        logic [31:0] old [R][C];
        int dr, dc;
        old = mdl;
        dr = (d == 0 || d == 1 || d == 7) ? -1 : (d >= 3 && d <= 5) ? 1 : 0;
        dc = (d >= 1 && d <= 3) ? 1 : (d >= 5) ? -1 : 0;
        if (!z) begin
            for (int r = 0; r < R; r++)
                for (int c = 0; c < C; c++)
                    if (m[r * C + c]) mdl[r][c] = old[(r - dr + R) % R][(c - dc + C) % C];
        end
    endtask

    task automatic do_shift(input int d, input logic z, input logic [N-1:0] m);
        @(negedge clk);
        shift_go = 1'b1; shift_zero = z; shift_dir = 3'(d); en_mask = m;
        @(negedge clk);
        shift_go = 1'b0; shift_zero = 1'b0;
        model_shift(d, z, m);
    endtask

    task automatic t_reset();
        check("R9 done low in reset", 32'(shift_done), 32'd0);
        check_grid("R9 reset clears grid");
    endtask

    task automatic t_host();
        load_pattern(32'hA5C3_0000);
        check_grid("R7 host write/read");
    endtask

    task automatic t_dirs();
        for (int d = 0; d < 8; d++) begin
            load_pattern(32'h1000_0000 * 32'(d + 1));
            do_shift(d, 1'b0, '1);
            check_grid("R1 R5 direction move");
        end
    endtask

    task automatic t_wrap();
        load_pattern(32'h0BAD_0000);
        do_shift(0, 1'b0, '1);
        host_row = 2'd3; host_col = 2'd2; #1;
        check("R2 north wrap row0->row3", host_rdata, 32'h0BAD_0000 ^ 32'h0202_0202);
        do_shift(3, 1'b0, '1);
        check_grid("R2 diagonal wrap");
    endtask

    task automatic t_zero();
        load_pattern(32'h7777_0000);
        do_shift(2, 1'b1, '1);
        check_grid("R3 zero-distance hold");
    endtask

    task automatic t_mask();
        load_pattern(32'h3C3C_0000);
        do_shift(6, 1'b0, 16'h5A5A);
        check_grid("R4 masked elements hold, still source");
        do_shift(5, 1'b0, 16'h0001);
        check_grid("R4 single enabled element");
    endtask

    task automatic t_host_blocked();
        load_pattern(32'h0F0F_0000);
        @(negedge clk);
        shift_go = 1'b1; shift_zero = 1'b1; shift_dir = 3'd0; en_mask = '1;
        host_wr = 1'b1; host_row = 2'd1; host_col = 2'd1; host_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        shift_go = 1'b0; shift_zero = 1'b0; host_wr = 1'b0;
        check_grid("R8 host write during shift ignored");
    endtask

    task automatic t_done();
        @(negedge clk);
        check("R6 done idle low", 32'(shift_done), 32'd0);
        shift_go = 1'b1; shift_zero = 1'b1;
        @(negedge clk);
        check("R6 done after first strobe", 32'(shift_done), 32'd1);
        @(negedge clk);
        shift_go = 1'b0; shift_zero = 1'b0;
        check("R6 done after second strobe", 32'(shift_done), 32'd1);
        @(negedge clk);
        check("R6 done single-cycle", 32'(shift_done), 32'd0);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; shift_go = 1'b0; shift_zero = 1'b0; shift_dir = 3'd0;
        en_mask = '1; host_wr = 1'b0; host_row = 2'd0; host_col = 2'd0; host_wdata = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                mdl[r][c] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_host();
        t_dirs();
        t_wrap();
        t_zero();
        t_mask();
        t_host_blocked();
        t_done();
        finish_run();
    end

endmodule